// File: doc/BRIEF.md
# UART with multiprocessor address filtering

This block is an asynchronous serial transmitter and receiver with a byte-wide control register. The register holds the three interrupt enables, the receiver and transmitter enables, the bit that selects nine-bit characters, the ninth bit to transmit and the ninth bit that was received. Side inputs select the shorter character sizes, parity, the double-speed baud mode and the multiprocessor filter. A shared prescaler divides the clock by `baud_div + 1` to make oversampling ticks, and each serial bit lasts 16 ticks, or 8 ticks in double-speed mode.

Software writes a character into a one-deep transmit buffer, which feeds a shift register. Turning the transmitter off takes effect only once both are empty. The receiver takes three majority-voted samples near the middle of each bit. It holds one finished character, together with its frame, parity and overrun status. When the receiver is switched off, all of that is discarded. In multiprocessor mode the receiver keeps only address frames. Three interrupt requests combine a status flag, its enable bit and a global enable.

Top module: `serial_mp_uart`

## Requirements
- R1: After reset the control register reads 0x00, `dre` is 1, `txd` is 1, and `rx_done`, `tx_done`, `frm_err`, `ovr_err`, `par_err` and all interrupt requests are 0.
- R2: Control bits 7..0 are: RX interrupt enable, TX interrupt enable, empty-buffer interrupt enable, receiver enable, transmitter enable, nine-bit size, received ninth bit, ninth bit to transmit. Bit 1 ignores writes and reads back the ninth bit of the buffered received character.
- R3: A frame is a 0 start bit, then the data bits LSB first, then an optional parity bit, then a 1 stop bit. The data width is 5, 6, 7 or 8 bits for `char_lo` = 0, 1, 2 or 3 when control bit 2 is 0, and 9 bits when control bit 2 is 1. One bit lasts (`baud_div`+1)*16 clocks, or (`baud_div`+1)*8 clocks when `dbl_speed` is 1.
- R4: A finished character appears on `data_rdata` (bit 8 on control bit 1) with `rx_done` set. A `data_rd` pulse clears `rx_done`, `frm_err`, `par_err` and `ovr_err`.
- R5: `frm_err` is set when the stop bit is received as 0. With `par_en` = 1 the parity bit makes the count of ones even (`par_odd` = 0) or odd (`par_odd` = 1), and `par_err` is set when the received parity bit breaks that rule.
- R6: If a frame completes while `rx_done` is still set, `ovr_err` is set, and the buffered character stays unchanged.
- R7: With `mp_en` = 1 the receiver drops every non-address frame without setting any flag. An address frame has ninth bit 1 in nine-bit mode, or a stop bit received as 1 in the shorter modes.
- R8: While the receiver enable is 0, `rx_done`, `frm_err`, `ovr_err`, `par_err` and the received character are all 0.
- R9: `data_wr` is accepted only while `dre` is 1, and it clears `dre`. A write while `dre` is 0 is ignored. `tx_done` is set when a stop bit finishes and the buffer is empty, and it is cleared by `tx_ack`.
- R10: When the transmitter enable is cleared, a character already in the buffer or the shift register is still sent in full. After that `txd` stays at 1, and characters written later are not sent.
- R11: `irq_rx`, `irq_tx` and `irq_dre` are each 1 exactly when `gie` is 1, the matching enable (bit 7, 6 or 5) is 1 and the matching flag (`rx_done`, `tx_done`, `dre`) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| data_wr | input | 1 | Write strobe for the transmit buffer |
| data_wdata | input | 8 | Character to transmit, low 8 bits |
| data_rd | input | 1 | Read strobe that consumes the received character |
| data_rdata | output | 8 | Received character, low 8 bits |
| tx_ack | input | 1 | Clears `tx_done` |
| char_lo | input | 2 | Low character-size select |
| par_en | input | 1 | Enables parity |
| par_odd | input | 1 | Selects odd parity |
| dbl_speed | input | 1 | Sets 8 ticks per bit instead of 16 |
| mp_en | input | 1 | Enables multiprocessor filtering |
| gie | input | 1 | Global interrupt enable |
| baud_div | input | DIV_W | Prescaler divisor minus one |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output, idles at 1 |
| rx_done | output | 1 | Receive complete |
| tx_done | output | 1 | Transmit complete |
| dre | output | 1 | Transmit buffer empty |
| frm_err | output | 1 | Frame error |
| ovr_err | output | 1 | Data overrun |
| par_err | output | 1 | Parity error |
| irq_rx | output | 1 | Receive-complete interrupt request |
| irq_tx | output | 1 | Transmit-complete interrupt request |
| irq_dre | output | 1 | Buffer-empty interrupt request |

## Verification
The embedded assertions check, on every cycle, the local rules:

- the tick spacing of the prescaler;
- that `dre` falls after an accepted write;
- that a deferred transmitter shutdown holds until the frame ends;
- that the line stays idle once the transmitter is off;
- that the buffer is kept on an overrun;
- that the flags are flushed while the receiver is off;
- that bit 1 of the control register cannot be written.

The bench scenarios cover what only whole frames can show. A loopback sweep runs every character size, every parity mode and both speeds, and checks the data, the ninth bit and the start-bit length. Driven frames check frame and parity errors, overrun, address filtering, the flush, the deferred shutdown and the gating of each interrupt.

// File: rtl/serial_mp_uart_pkg.sv
package serial_mp_uart_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } phase_e;

  localparam int CHAR_W = 9;
  localparam int CNT_W  = 4;
endpackage

// File: rtl/smu_baud.sv
module smu_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == '0) cnt_d = div;
    else             cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == '0);

  // R3: with a nonzero divisor no two ticks are adjacent
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);
endmodule

// File: rtl/smu_tx.sv
module smu_tx
  import serial_mp_uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              dbl,
  input  logic              txen,
  input  logic [3:0]        nbits,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              wr,
  input  logic [CHAR_W-1:0] wdata,
  output logic              txd,
  output logic              dre,
  output logic              txc_set
);
  phase_e            st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [3:0]        idx_q, idx_d;
  logic [CHAR_W-1:0] sh_q, sh_d, buf_q, buf_d;
  logic              full_q, full_d, par_q, par_d, act_q, act_d;
  logic [CNT_W-1:0]  last;

  assign last = dbl ? CNT_W'(7) : CNT_W'(15);

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; idx_d = idx_q; sh_d = sh_q;
    buf_d = buf_q; full_d = full_q; par_d = par_q; txc_set = 1'b0;
    act_d = txen | (act_q & ((st_q != PH_IDLE) | full_q));
    if (wr && !full_q) begin
      buf_d  = wdata;
      full_d = 1'b1;
    end
    if (st_q == PH_IDLE) begin
      if (act_q && full_q) begin
        sh_d = buf_q; full_d = 1'b0; st_d = PH_START;
        cnt_d = '0; par_d = 1'b0; idx_d = '0;
      end
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == last) begin
        cnt_d = '0;
        case (st_q)
          PH_START: st_d = PH_DATA;
          PH_DATA: begin
            par_d = par_q ^ sh_q[0];
            sh_d  = sh_q >> 1;
            idx_d = idx_q + 1'b1;
            if (idx_q == nbits - 1'b1) st_d = par_en ? PH_PAR : PH_STOP;
          end
          PH_PAR: st_d = PH_STOP;
          default: begin
            st_d = PH_IDLE;
            if (!full_q) txc_set = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PH_IDLE; cnt_q <= '0; idx_q <= '0; sh_q <= '0;
      buf_q <= '0; full_q <= 1'b0; par_q <= 1'b0; act_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; idx_q <= idx_d; sh_q <= sh_d;
      buf_q <= buf_d; full_q <= full_d; par_q <= par_d; act_q <= act_d;
    end
  end

  logic line;
  always_comb begin
    case (st_q)
      PH_START: line = 1'b0;
      PH_DATA:  line = sh_q[0];
      PH_PAR:   line = par_q ^ par_odd;
      default:  line = 1'b1;
    endcase
  end

  assign txd = act_q ? line : 1'b1;
  assign dre = !full_q;

  // R9: an accepted write fills the buffer
  a_r9_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && dre) |=> !dre);
  // R10: the transmitter stays active while a frame is under way
  a_r10_defer: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && st_q != PH_IDLE) |=> act_q);
  // R10: the line is idle once the transmitter is off
  a_r10_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !txen) |=> txd);
endmodule

// File: rtl/smu_rx.sv
module smu_rx
  import serial_mp_uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              dbl,
  input  logic              rxen,
  input  logic [3:0]        nbits,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              mp_en,
  input  logic              rxd,
  input  logic              rd,
  output logic [CHAR_W-1:0] word,
  output logic              rxc,
  output logic              fe,
  output logic              dor,
  output logic              pe
);
  logic s1_q, s2_q;
  phase_e            st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, last, mid;
  logic [3:0]        idx_q, idx_d;
  logic [CHAR_W-1:0] sh_q, sh_d, buf_q, buf_d, frame_word;
  logic [1:0]        ones_q, ones_d, tot;
  logic              par_q, par_d, pbad_q, pbad_d;
  logic              rxc_q, rxc_d, fe_q, fe_d, dor_q, dor_d, pe_q, pe_d;
  logic              done, stop_bit, bitv, addr, accept;

  assign last = dbl ? CNT_W'(7) : CNT_W'(15);
  assign mid  = dbl ? CNT_W'(4) : CNT_W'(8);
  assign tot  = ones_q + {1'b0, s2_q};
  assign bitv = tot[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1; s2_q <= 1'b1;
    end else begin
      s1_q <= rxd; s2_q <= s1_q;
    end
  end

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; idx_d = idx_q; sh_d = sh_q;
    ones_d = ones_q; par_d = par_q; pbad_d = pbad_q;
    done = 1'b0; stop_bit = 1'b0;
    if (!rxen) begin
      st_d = PH_IDLE;
    end else if (st_q == PH_IDLE) begin
      if (!s2_q) begin
        st_d = PH_START; cnt_d = '0; ones_d = '0;
      end
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == mid - 1'b1 || cnt_q == mid) ones_d = tot;
      if (cnt_q == mid + 1'b1) begin
        case (st_q)
          PH_START: if (bitv) st_d = PH_IDLE;
          PH_DATA: begin
            sh_d  = {bitv, sh_q[CHAR_W-1:1]};
            par_d = par_q ^ bitv;
          end
          PH_PAR: pbad_d = ((par_q ^ par_odd) != bitv);
          default: begin
            done = 1'b1; stop_bit = bitv; st_d = PH_IDLE;
          end
        endcase
      end
      if (cnt_q == last) begin
        cnt_d = '0; ones_d = '0;
        case (st_q)
          PH_START: begin
            st_d = PH_DATA; idx_d = '0; par_d = 1'b0; pbad_d = 1'b0;
          end
          PH_DATA: begin
            idx_d = idx_q + 1'b1;
            if (idx_q == nbits - 1'b1) st_d = par_en ? PH_PAR : PH_STOP;
          end
          PH_PAR: st_d = PH_STOP;
          default: st_d = st_q;
        endcase
      end
    end
  end

  assign frame_word = sh_q >> (4'd9 - nbits);
  assign addr   = (nbits == 4'd9) ? frame_word[8] : stop_bit;
  assign accept = done && (!mp_en || addr);

  always_comb begin
    buf_d = buf_q; rxc_d = rxc_q; fe_d = fe_q; dor_d = dor_q; pe_d = pe_q;
    if (!rxen) begin
      buf_d = '0; rxc_d = 1'b0; fe_d = 1'b0; dor_d = 1'b0; pe_d = 1'b0;
    end else begin
      if (rd) begin
        rxc_d = 1'b0; fe_d = 1'b0; dor_d = 1'b0; pe_d = 1'b0;
      end
      if (accept) begin
        if (rxc_q && !rd) begin
          dor_d = 1'b1;
        end else begin
          buf_d = frame_word; rxc_d = 1'b1; fe_d = !stop_bit;
          pe_d  = par_en & pbad_q; dor_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PH_IDLE; cnt_q <= '0; idx_q <= '0; sh_q <= '0; ones_q <= '0;
      par_q <= 1'b0; pbad_q <= 1'b0; buf_q <= '0;
      rxc_q <= 1'b0; fe_q <= 1'b0; dor_q <= 1'b0; pe_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; idx_q <= idx_d; sh_q <= sh_d; ones_q <= ones_d;
      par_q <= par_d; pbad_q <= pbad_d; buf_q <= buf_d;
      rxc_q <= rxc_d; fe_q <= fe_d; dor_q <= dor_d; pe_q <= pe_d;
    end
  end

  assign word = buf_q;
  assign rxc  = rxc_q;
  assign fe   = fe_q;
  assign dor  = dor_q;
  assign pe   = pe_q;

  // R6: an overrun leaves the buffered character in place
  a_r6_keep_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rxc_q && !rd) |=> ($stable(buf_q) && dor_q));
  // R8: a disabled receiver holds no flags
  a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !rxen |=> (!rxc_q && !fe_q && !dor_q && !pe_q));
endmodule

// File: rtl/serial_mp_uart.sv
module serial_mp_uart
  import serial_mp_uart_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             data_wr,
  input  logic [7:0]       data_wdata,
  input  logic             data_rd,
  output logic [7:0]       data_rdata,
  input  logic             tx_ack,
  input  logic [1:0]       char_lo,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             dbl_speed,
  input  logic             mp_en,
  input  logic             gie,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             rxd,
  output logic             txd,
  output logic             rx_done,
  output logic             tx_done,
  output logic             dre,
  output logic             frm_err,
  output logic             ovr_err,
  output logic             par_err,
  output logic             irq_rx,
  output logic             irq_tx,
  output logic             irq_dre
);
  // hi_q holds control bits 7..2, tx9_q holds bit 0
  logic [5:0] hi_q, hi_d;
  logic       tx9_q, tx9_d, txc_q, txc_d, txc_set, tick;
  logic [3:0] nbits;
  logic [CHAR_W-1:0] rx_word;

  always_comb begin
    hi_d = hi_q; tx9_d = tx9_q;
    if (reg_wr) begin
      hi_d  = reg_wdata[7:2];
      tx9_d = reg_wdata[0];
    end
    txc_d = txc_set | (txc_q & !tx_ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0; tx9_q <= 1'b0; txc_q <= 1'b0;
    end else begin
      hi_q <= hi_d; tx9_q <= tx9_d; txc_q <= txc_d;
    end
  end

  assign nbits = hi_q[0] ? 4'd9 : (4'd5 + {2'b00, char_lo});

  smu_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  smu_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dbl(dbl_speed), .txen(hi_q[1]),
    .nbits(nbits), .par_en(par_en), .par_odd(par_odd), .wr(data_wr),
    .wdata({tx9_q, data_wdata}), .txd(txd), .dre(dre), .txc_set(txc_set)
  );

  smu_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dbl(dbl_speed), .rxen(hi_q[2]),
    .nbits(nbits), .par_en(par_en), .par_odd(par_odd), .mp_en(mp_en),
    .rxd(rxd), .rd(data_rd), .word(rx_word), .rxc(rx_done), .fe(frm_err),
    .dor(ovr_err), .pe(par_err)
  );

  assign reg_rdata  = {hi_q, rx_word[8], tx9_q};
  assign data_rdata = rx_word[7:0];
  assign tx_done    = txc_q;
  assign irq_rx     = gie & hi_q[5] & rx_done;
  assign irq_tx     = gie & hi_q[4] & txc_q;
  assign irq_dre    = gie & hi_q[3] & dre;

  // R2: bit 1 of the control register cannot be written
  a_r2_bit1_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && $stable(rx_word[8])) |=> (reg_rdata[1] == $past(rx_word[8])));
  // R9: tx_done is released by tx_ack unless a new frame ends
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ack && !txc_set) |=> !tx_done);
endmodule

// File: tb/sim_serial_mp_uart.sv
module sim_serial_mp_uart;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, data_wr = 0, data_rd = 0, tx_ack = 0;
  logic [7:0] reg_wdata = 0, data_wdata = 0;
  logic [1:0] char_lo = 2'd3;
  logic par_en = 0, par_odd = 0, dbl_speed = 0, mp_en = 0, gie = 0;
  logic [11:0] baud_div = 12'd1;
  logic drv = 1'b1, lb = 1'b0;
  logic [7:0] reg_rdata, data_rdata;
  logic txd, rx_done, tx_done, dre, frm_err, ovr_err, par_err;
  logic irq_rx, irq_tx, irq_dre, rxd_w;
  int nchk = 0, nfail = 0, cyc = 0;

  assign rxd_w = lb ? txd : drv;
  always #4 clk = ~clk;

  serial_mp_uart u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .data_wr(data_wr), .data_wdata(data_wdata),
    .data_rd(data_rd), .data_rdata(data_rdata), .tx_ack(tx_ack),
    .char_lo(char_lo), .par_en(par_en), .par_odd(par_odd),
    .dbl_speed(dbl_speed), .mp_en(mp_en), .gie(gie), .baud_div(baud_div),
    .rxd(rxd_w), .txd(txd), .rx_done(rx_done), .tx_done(tx_done), .dre(dre),
    .frm_err(frm_err), .ovr_err(ovr_err), .par_err(par_err),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_dre(irq_dre)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_cr(input logic [7:0] v);
    @(negedge clk); reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic wr_data(input logic [7:0] v);
    @(negedge clk); data_wr = 1; data_wdata = v;
    @(negedge clk); data_wr = 0;
  endtask

  task automatic rd_data();
    @(negedge clk); data_rd = 1;
    @(negedge clk); data_rd = 0;
  endtask

  task automatic ack_tx();
    @(negedge clk); tx_ack = 1;
    @(negedge clk); tx_ack = 0;
  endtask

  task automatic wait_rx(input int lim);
    for (int i = 0; i < lim && !rx_done; i++) @(negedge clk);
  endtask

  task automatic wait_tx(input int lim);
    for (int i = 0; i < lim && !tx_done; i++) @(negedge clk);
  endtask

  function automatic int bitlen();
    return (int'(baud_div) + 1) * (dbl_speed ? 8 : 16);
  endfunction

  // drive one frame on the serial input: start, data LSB first, parity, stop
  task automatic send(input logic [8:0] d, input int nb, input bit flip_par,
                      input bit stop_v);
    int bp;
    logic p;
    bp = bitlen();
    p = par_odd;
    @(negedge clk); drv = 0; cyc_n(bp);
    for (int i = 0; i < nb; i++) begin
      drv = d[i]; p = p ^ d[i]; cyc_n(bp);
    end
    if (par_en) begin drv = p ^ flip_par; cyc_n(bp); end
    drv = stop_v; cyc_n(bp);
    drv = 1; cyc_n(2 * bp);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 190000) begin
        nfail++; nchk++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] vals [4];
    vals[0] = 8'h00; vals[1] = 8'hFF; vals[2] = 8'hA5; vals[3] = 8'h5A;
    cyc_n(3);
    rst_n = 1;
    cyc_n(2);
    // R1 reset state
    chk(reg_rdata == 8'h00, "R1 ctrl", reg_rdata, 0);
    chk(dre && txd, "R1 dre/txd", {dre, txd}, 3);
    chk({rx_done, tx_done, frm_err, ovr_err, par_err} == 0, "R1 flags",
        {rx_done, tx_done, frm_err, ovr_err, par_err}, 0);
    chk({irq_rx, irq_tx, irq_dre} == 0, "R1 irq", {irq_rx, irq_tx, irq_dre}, 0);

    // R2 bit 1 is read-only, other bits read back
    wr_cr(8'h02); cyc_n(1);
    chk(reg_rdata == 8'h00, "R2 bit1 ro", reg_rdata, 0);
    wr_cr(8'hED); cyc_n(1);
    chk(reg_rdata == 8'hED, "R2 readback", reg_rdata, 8'hED);
    wr_cr(8'h00);

    // R3 loopback sweep over sizes, parity modes and speeds
    lb = 1;
    for (int sz = 5; sz <= 9; sz++)
      for (int pm = 0; pm < 3; pm++)
        for (int ds = 0; ds < 2; ds++) begin
          char_lo = (sz == 9) ? 2'd3 : 2'(sz - 5);
          par_en = (pm != 0); par_odd = (pm == 2); dbl_speed = ds[0];
          for (int k = 0; k < 4; k++) begin
            logic [8:0] expw;
            int lowc, bp;
            expw = {k[0], vals[k]} & 9'((1 << sz) - 1);
            bp = bitlen();
            wr_cr(8'h18 | ((sz == 9) ? 8'h04 : 8'h00) | {7'd0, k[0]});
            wr_data(vals[k]);
            if (k == 1) begin
              lowc = 0;
              for (int i = 0; i < 300 && txd; i++) @(negedge clk);
              for (int i = 0; i < 300 && !txd; i++) begin @(negedge clk); lowc++; end
              chk(lowc >= bp - 3 && lowc <= bp + 1, "R3 bit period", lowc, bp);
            end
            wait_rx(1500);
            chk(rx_done && data_rdata == expw[7:0], "R3 loopback data",
                data_rdata, expw[7:0]);
            if (sz == 9)
              chk(reg_rdata[1] == expw[8], "R2 ninth bit", reg_rdata[1], expw[8]);
            chk(!frm_err && !par_err, "R5 clean frame", {frm_err, par_err}, 0);
            rd_data();
            chk(!rx_done, "R4 read clears", rx_done, 0);
            wait_tx(1500);
            chk(tx_done && dre, "R9 tx done", {tx_done, dre}, 3);
            ack_tx();
            chk(!tx_done, "R9 ack", tx_done, 0);
          end
        end

    // driven frames, 8-bit normal speed
    lb = 0; char_lo = 2'd3; par_en = 0; par_odd = 0; dbl_speed = 0;
    wr_cr(8'h10);
    send(9'h03C, 8, 0, 0);
    chk(rx_done && frm_err && data_rdata == 8'h3C, "R5 frame error",
        {rx_done, frm_err}, 3);
    rd_data();
    chk(!frm_err, "R4 read clears fe", frm_err, 0);

    par_en = 1;
    send(9'h007, 8, 1, 1);
    chk(par_err, "R5 even parity bad", par_err, 1);
    rd_data();
    send(9'h007, 8, 0, 1);
    chk(rx_done && !par_err, "R5 even parity ok", par_err, 0);
    rd_data();
    par_odd = 1;
    send(9'h0C3, 8, 0, 1);
    chk(rx_done && !par_err && data_rdata == 8'hC3, "R5 odd parity ok", par_err, 0);
    rd_data();
    send(9'h0C3, 8, 1, 1);
    chk(par_err, "R5 odd parity bad", par_err, 1);
    rd_data();
    par_en = 0; par_odd = 0;

    // R6 overrun
    send(9'h011, 8, 0, 1);
    send(9'h022, 8, 0, 1);
    chk(rx_done && ovr_err, "R6 overrun flag", ovr_err, 1);
    chk(data_rdata == 8'h11, "R6 buffer kept", data_rdata, 8'h11);
    rd_data();
    chk(!ovr_err && !rx_done, "R4 read clears dor", {ovr_err, rx_done}, 0);

    // R8 flush on receiver disable
    send(9'h0F0, 8, 0, 0);
    chk(rx_done && frm_err, "R8 setup", {rx_done, frm_err}, 3);
    wr_cr(8'h00); cyc_n(1);
    chk({rx_done, frm_err, ovr_err, par_err} == 0 && data_rdata == 0,
        "R8 flushed", {rx_done, frm_err, data_rdata}, 0);
    wr_cr(8'h10);

    // R7 multiprocessor filter, nine-bit mode
    mp_en = 1;
    wr_cr(8'h14);
    send(9'h0AB, 9, 0, 1);
    chk(!rx_done, "R7 data frame dropped", rx_done, 0);
    send(9'h1CD, 9, 0, 1);
    chk(rx_done && data_rdata == 8'hCD && reg_rdata[1], "R7 address accepted",
        data_rdata, 8'hCD);

    // R11 interrupt gating, with rx_done set and dre set
    gie = 0; wr_cr(8'hB4); cyc_n(1);
    chk(!irq_rx && !irq_dre, "R11 gie off", {irq_rx, irq_dre}, 0);
    gie = 1; cyc_n(1);
    chk(irq_rx && irq_dre, "R11 gie on", {irq_rx, irq_dre}, 3);
    wr_cr(8'h34); cyc_n(1);
    chk(!irq_rx && irq_dre, "R11 rx enable off", {irq_rx, irq_dre}, 1);
    chk(!irq_tx, "R11 tx flag clear", irq_tx, 0);
    rd_data();

    // R7 shorter mode: stop bit 0 counts as data frame
    wr_cr(8'h10);
    send(9'h055, 8, 0, 0);
    chk(!rx_done && !frm_err, "R7 short mode drop", {rx_done, frm_err}, 0);
    mp_en = 0;

    // R10 deferred transmitter disable
    lb = 1;
    wr_cr(8'h18);
    wr_data(8'h5A);
    wr_cr(8'h10);
    wait_rx(1500);
    chk(rx_done && data_rdata == 8'h5A, "R10 pending sent", data_rdata, 8'h5A);
    rd_data();
    wait_tx(1500);
    chk(tx_done, "R10 tx done", tx_done, 1);
    wr_cr(8'h50); cyc_n(1);
    chk(irq_tx, "R11 tx irq", irq_tx, 1);
    ack_tx(); cyc_n(1);
    chk(!irq_tx, "R11 tx irq cleared", irq_tx, 0);
    wr_data(8'h33);
    chk(!dre, "R9 write accepted", dre, 0);
    begin
      int lows;
      lows = 0;
      for (int i = 0; i < 600; i++) begin @(negedge clk); if (!txd) lows++; end
      chk(lows == 0 && !rx_done, "R10 disabled line idle", lows, 0);
    end
    wr_data(8'h77);
    wr_cr(8'h18);
    wait_rx(1500);
    chk(rx_done && data_rdata == 8'h33, "R9 write while full ignored",
        data_rdata, 8'h33);
    rd_data();
    wait_tx(1500);
    ack_tx();

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule